// File: doc/BRIEF.md
# Nine-bit serial frame transmitter

This block sends one asynchronous frame of eleven bit times on a single output line. A frame has a low start bit, eight data bits with the least significant bit first, a ninth bit taken from a separate control input, and a high stop bit. A write strobe captures the data byte and the ninth bit together. The frame then starts on the next rollover of a free-running divide-by-16 counter, which advances on an external enable pulsed at sixteen times the baud rate.

The frame goes out through a zero-filled shift register. No bit counter is used. Each bit time the register moves one place toward the line and a zero enters at the far end. When only the stop bit is left in the register, the next rollover sends it and ends the frame. At that same rollover the busy indication drops and a sticky completion flag is set. The flag stays set until the clear input is pulsed. A write that arrives while a frame is in progress is dropped.

Top module: `ninebit_tx`

## Requirements
- R1: While reset is asserted and after it is released, the line output is high, busy is low and the completion flag is low.
- R2: A write strobe sampled while busy is low is accepted. Busy is high from the next cycle, and the line stays high until the frame's first rollover.
- R3: After an accepted write, the line carries 0 (start), then data bits 0 to 7 in that order, then the captured ninth bit, then 1 (stop). The line changes only on a rollover of the divide-by-16 counter.
- R4: The divide-by-16 counter is free running. Starting from zero at reset, it rolls over on every sixteenth cycle in which the tick input is high. Cycles with tick low do not advance it, so every bit is held for exactly 16 ticks.
- R5: On the 11th rollover after the accepted write, busy falls, the completion flag is set and the line returns to the stop level.
- R6: The completion flag holds until a cycle with the clear input high. The clear takes effect one cycle later. When completion and clear fall in the same cycle, the flag is set.
- R7: A write strobe while busy is high is ignored. The frame in progress continues unchanged and ends on its original rollover.
- R8: Whenever busy is low the line is high. A frame written right after the previous one ends keeps the stop level for at least 16 ticks before the next start bit.
- R9: Data and ninth-bit inputs are sampled only in the cycle of an accepted write. Later changes to them do not alter the frame.
- R10: A set completion flag does not block a new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulsed at 16x the baud rate |
| wr_stb | input | 1 | Write strobe for a new frame |
| wr_data | input | 8 | Data byte, sent LSB first |
| bit9_in | input | 1 | Ninth bit of the frame |
| flag_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | High while a frame is being sent |
| done_flag | output | 1 | Sticky completion flag |

## Verification
Two situations are hard to reach from the ports. The first is a completion landing in the same cycle as a clear. The second is a write arriving mid-frame. The bench holds the clear input high for an entire frame, so the set-priority cycle is hit whatever the divider's phase, and it strobes a different byte halfway through a frame. A cycle-by-cycle reference built from the requirements tracks ticks since reset and rollovers since each accepted write. That reference is checked over every byte and ninth-bit value, and again under sparse and irregular tick patterns.

// File: rtl/ntx_pkg.sv
package ntx_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/ntx_baud_div.sv
module ntx_baud_div #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  output logic roll
);
  localparam int CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OSR - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) begin
      if (cnt_q == CNT_MAX) cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign roll = tick_en && (cnt_q == CNT_MAX);

  // R4: the counter only moves on enabled ticks
  a_r4_pause_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/ntx_shifter.sv
module ntx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] data,
  input  logic              bit9,
  output logic              line,
  output logic              last_pat
);
  localparam int FRAME_W = DATA_W + 3;
  localparam logic [FRAME_W-1:0] ONLY_STOP = FRAME_W'(1);

  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic               line_q, line_d;

  always_comb begin
    sreg_d = sreg_q;
    line_d = line_q;
    if (load) begin
      sreg_d = {1'b1, bit9, data, 1'b0};
    end else if (shift) begin
      line_d = sreg_q[0];
      sreg_d = {1'b0, sreg_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      line_q <= 1'b1;
    end else begin
      sreg_q <= sreg_d;
      line_q <= line_d;
    end
  end

  assign line     = line_q;
  assign last_pat = (sreg_q == ONLY_STOP);

  // R3: every shift brings a zero in at the far end
  a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    shift |=> (sreg_q[FRAME_W-1] == 1'b0));
  // R9: the frame is frozen between shifts
  a_r9_frame_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sreg_q));
endmodule

// File: rtl/ntx_ctrl.sv
module ntx_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic clr,
  input  logic roll,
  input  logic last_pat,
  output logic load,
  output logic shift,
  output logic busy,
  output logic flag
);
  import ntx_pkg::*;
  localparam int FRAME_W = DATA_W + 3;
  localparam int RC_W    = $clog2(FRAME_W + 1);

  tx_state_e state_q, state_d;
  logic      flag_q, flag_d;
  logic      finish;

  assign load   = wr && (state_q == TX_IDLE);
  assign shift  = roll && (state_q == TX_SEND);
  assign finish = shift && last_pat;

  always_comb begin
    state_d = state_q;
    if (load)        state_d = TX_SEND;
    else if (finish) state_d = TX_IDLE;
  end

  always_comb begin
    flag_d = flag_q;
    if (finish)   flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign busy = (state_q == TX_SEND);
  assign flag = flag_q;

  // checker: shifts since the accepted write
  logic [RC_W-1:0] rolls_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rolls_q <= '0;
    else if (load)  rolls_q <= '0;
    else if (shift) rolls_q <= rolls_q + 1'b1;
  end

  // R5: the end pattern appears on the 11th rollover
  a_r5_eleventh_roll: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> (rolls_q == RC_W'(FRAME_W - 1)));
  // R5: the flag rises only as busy falls
  a_r5_flag_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $fell(busy));
  // R6: the flag is sticky until cleared
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
endmodule

// File: rtl/ninebit_tx.sv
module ninebit_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_in,
  input  logic              flag_clr,
  output logic              txd,
  output logic              busy,
  output logic              done_flag
);
  logic rst_meta_q, rst_sync_q;
  logic roll, load, shift, last_pat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ntx_baud_div #(.OSR(OSR)) i_div (
    .clk(clk), .rst_n(rst_sync_q), .tick_en(tick16), .roll(roll)
  );

  ntx_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .wr(wr_stb), .clr(flag_clr),
    .roll(roll), .last_pat(last_pat), .load(load), .shift(shift),
    .busy(busy), .flag(done_flag)
  );

  ntx_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_sync_q), .load(load), .shift(shift),
    .data(wr_data), .bit9(bit9_in), .line(txd), .last_pat(last_pat)
  );

  // R8: idle line is high
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> txd);
  // R3: the line only moves on a rollover
  a_r3_moves_on_roll: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !roll |=> $stable(txd));
endmodule

// File: tb/test_ninebit_tx.sv
module test_ninebit_tx;
  logic       clk = 1'b0;
  logic       rst_n, tick16, wr_stb, bit9_in, flag_clr;
  logic [7:0] wr_data;
  logic       txd, busy, done_flag;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    chk_en = 1'b0;
  int    tick_mode = 3;
  bit    done_sim = 1'b0;

  always #4 clk = ~clk;

  ninebit_tx i_ninebit_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_stb(wr_stb),
    .wr_data(wr_data), .bit9_in(bit9_in), .flag_clr(flag_clr),
    .txd(txd), .busy(busy), .done_flag(done_flag)
  );

  // reference built from the requirements
  int         m_tick, m_k;
  bit         m_busy, m_flag, m_b9;
  logic [7:0] m_data;
  wire        m_roll = tick16 && (m_tick % 16 == 15);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick <= 0; m_k <= 0; m_busy <= 0; m_flag <= 0; m_b9 <= 0; m_data <= 0;
    end else begin
      if (tick16) m_tick <= m_tick + 1;
      if (wr_stb && !m_busy) begin
        m_busy <= 1; m_k <= 0; m_data <= wr_data; m_b9 <= bit9_in;
      end else if (m_roll && m_busy) begin
        m_k <= m_k + 1;
        if (m_k == 10) m_busy <= 0;
      end
      if (m_roll && m_busy && m_k == 10) m_flag <= 1;
      else if (flag_clr)                 m_flag <= 0;
    end
  end

  function automatic bit exp_line();
    if (!m_busy || m_k == 0) return 1'b1;
    if (m_k == 1)            return 1'b0;
    if (m_k <= 9)            return m_data[m_k-2];
    return m_b9;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done_sim) begin
      check(txd == exp_line(), cur_req, "txd", txd, exp_line());
      check(busy == m_busy, "R5", "busy", busy, m_busy);
      check(done_flag == m_flag, "R6", "done_flag", done_flag, m_flag);
    end
  end

  // tick generator: 0 every cycle, 1 every third, 2 irregular, 3 off
  initial begin
    logic [7:0] lfsr = 8'hA7;
    int cyc = 0;
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (tick_mode)
        0:       tick16 = 1'b1;
        1:       tick16 = (cyc % 3 == 0);
        2:       tick16 = lfsr[0] | lfsr[2];
        default: tick16 = 1'b0;
      endcase
    end
  end

  task automatic send(input logic [7:0] d, input logic b9);
    @(negedge clk);
    wr_data = d; bit9_in = b9; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = ~d; bit9_in = ~b9; // R9: later changes ignored
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; wr_data = 8'h00; bit9_in = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1", "txd in reset", txd, 1);
    check(busy == 1'b0, "R1", "busy in reset", busy, 0);
    check(done_flag == 1'b0, "R1", "flag in reset", done_flag, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b0 && done_flag == 1'b0, "R1", "after reset",
          {txd, busy, done_flag}, 3'b100);
    chk_en = 1'b1;

    // R4: no ticks, so the frame never starts
    cur_req = "R4";
    send(8'h5A, 1'b1);
    check(busy == 1'b1 && txd == 1'b1, "R2", "accepted, line high", {busy, txd}, 2'b11);
    repeat (40) @(negedge clk);
    check(txd == 1'b1 && busy == 1'b1, "R4", "paused without ticks", {txd, busy}, 2'b11);
    tick_mode = 0;
    wait_idle();

    // R3 sweep over every byte and ninth bit; R10 flag left set
    cur_req = "R3";
    for (int d = 0; d < 256; d++) begin
      for (int b = 0; b < 2; b++) begin
        if (d == 1 && b == 0)
          check(done_flag == 1'b1, "R10", "flag set before write", done_flag, 1);
        send(8'(d), 1'(b));
        wait_idle();
        if (d % 64 == 63 && b == 1) begin
          @(negedge clk); flag_clr = 1'b1;
          @(negedge clk); flag_clr = 1'b0;
          check(done_flag == 1'b0, "R6", "flag cleared", done_flag, 0);
        end
      end
    end

    // R7: write during a frame
    cur_req = "R7";
    send(8'hA5, 1'b1);
    repeat (50) @(negedge clk);
    send(8'h3C, 1'b0);
    check(busy == 1'b1, "R7", "still busy", busy, 1);
    wait_idle();
    check(done_flag == 1'b1 && busy == 1'b0, "R7", "ends on time",
          {done_flag, busy}, 2'b10);

    // R6: clear held across the completion cycle
    cur_req = "R6";
    flag_clr = 1'b1;
    send(8'hC3, 1'b0);
    wait_idle();
    check(done_flag == 1'b1, "R6", "set wins over clear", done_flag, 1);
    @(negedge clk);
    check(done_flag == 1'b0, "R6", "clear one cycle later", done_flag, 0);
    flag_clr = 1'b0;

    // R8: back-to-back frames
    cur_req = "R8";
    for (int i = 0; i < 4; i++) begin
      send(8'(8'h11 * i), 1'(i));
      wait_idle();
    end

    // R4: sparse and irregular ticks
    cur_req = "R4";
    for (int md = 1; md <= 2; md++) begin
      tick_mode = md;
      for (int i = 0; i < 4; i++) begin
        send(8'(8'h96 ^ (i * 37)), 1'(i + md));
        wait_idle();
      end
    end
    repeat (5) @(negedge clk);

    done_sim = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_sim) begin
      done_sim = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule